// File: doc/BRIEF.md
# PCI Target Bridge for 8-bit Peripherals

This block sits on the target side of a 32-bit multiplexed PCI address/data bus. It gives slow byte-wide devices such as boot ROM, flash and simple I/O registers a window in memory space. A single-data-phase memory read or write whose top address byte matches a fixed window base is claimed. The block then turns the four byte-enable pins into active-low peripheral strobes: read, write and data strobe. It drives a chip-enable line that surrounds the strobe, and it presents the lower 24 address bits to the device. The upper bits of that address stay visible, so an external decoder can select among several devices.

Each transfer moves one byte in the low lane of a 32-bit word. Software packs and unpacks the bytes. A wait-count input sets how long the strobe is held. Target-ready is pulsed once when the strobe ends. While a transfer is active, the parity pins are driven to fixed levels and the host's parity checker is disabled. Configuration cycles and attempts to burst are ended with a target-abort. No strobe is issued for them.

Top module: `pbus_bridge`

## Requirements
- R1: After reset, with no bus activity: trdy_n, devsel_n, stop_n and ce_n are 1. cbe_oe, ad_oe, par_oe and perr_oe are 0. parchk_en is 1.
- R2: An address phase with command 4'b0110 (memory read) or 4'b0111 (memory write) is claimed, and devsel_n goes low, only when ad_in[31:24] equals the window base. Other addresses leave every output at its idle value.
- R3: While the pins are taken over, cbe_n_out bit 0 is the read strobe, bit 1 the write strobe, bit 2 the data strobe and bit 3 is held at 1. All strobes are active low. A read lowers bits 0 and 2, a write lowers bits 1 and 2, and bits 0 and 1 are never low together.
- R4: The strobe stays low for exactly wait_cfg+1 cycles.
- R5: ce_n goes low one cycle before the strobe falls and returns high one cycle after the strobe rises.
- R6: trdy_n is low for exactly one cycle per transfer (with irdy_n low), in the cycle right after the strobe's last low cycle.
- R7: On a read, pdata_in is sampled on the last strobe cycle. It is returned during the trdy_n cycle as ad_out[7:0], with ad_out[31:8] zero and ad_oe high.
- R8: paddr carries ad_in[23:0] of the address phase. On a write, pdata_out carries ad_in[7:0] of the first data phase for the whole strobe, even after ad_in changes.
- R9: While devsel_n is low, par_oe and perr_oe are 1, par_out is 0, perr_n_out is 1 and parchk_en is 0. parchk_en returns to 1 when the transfer ends.
- R10: A configuration command (4'b1010 or 4'b1011) is answered with target-abort: stop_n goes low with devsel_n high. It issues no strobe and no trdy_n.
- R11: A claimed cycle in which frame_n is still low in its first data phase (a burst) is answered with target-abort. It issues no strobe and no trdy_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Cycle frame from the master |
| irdy_n | input | 1 | Initiator ready |
| ad_in | input | 32 | Address/data bus as seen by the block |
| cbe_n_in | input | 4 | Command / byte enables from the master |
| wait_cfg | input | 4 | Strobe wait cycles, 0 to 15 |
| pdata_in | input | 8 | Read data from the peripheral |
| ad_out | output | 32 | Read data word toward the bus |
| ad_oe | output | 1 | Output enable for ad_out |
| cbe_n_out | output | 4 | Peripheral strobes on the byte-enable pins |
| cbe_oe | output | 1 | Output enable for cbe_n_out |
| par_out | output | 1 | Fixed parity pin level |
| par_oe | output | 1 | Parity pin output enable |
| perr_n_out | output | 1 | Fixed parity-error pin level |
| perr_oe | output | 1 | Parity-error pin output enable |
| parchk_en | output | 1 | Enable for the host's parity checker |
| trdy_n | output | 1 | Target ready |
| devsel_n | output | 1 | Device select |
| stop_n | output | 1 | Stop, used here for target-abort |
| ce_n | output | 1 | Global peripheral chip enable |
| paddr | output | 24 | Peripheral address |
| pdata_out | output | 8 | Write data to the peripheral |

## Verification
Some behaviour is checked on every cycle by assertions. Read and write strobes are never low together. Each strobe is preceded by an active chip enable. The ready pulse lasts one cycle. An abort never overlaps device select, ready or the strobe pins. Parity pins are held whenever the device is selected. Other behaviour can only be shown by the bench scenarios, because it depends on counts and data across many cycles. These cover the exact strobe width for several wait settings, the ordering of chip enable, strobe and ready, the return of the byte sampled on the last strobe cycle, and the write data held after the bus moves on. The scenarios also show that windows outside the base and configuration or burst cycles produce no strobes.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int PADDR_W = 24;
    localparam int PDATA_W = 8;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;
    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DECODE,
        S_LEAD,
        S_STROBE,
        S_READY,
        S_ABORT
    } state_t;

    typedef struct packed {
        state_t              st;
        logic                is_wr;
        logic [PADDR_W-1:0]  addr;
        logic [PDATA_W-1:0]  wdata;
        logic [PDATA_W-1:0]  rdata;
    } ctl_t;

endpackage

// File: rtl/pbus_decode.sv
module pbus_decode #(
    parameter int          SEL_W = 8,
    parameter logic [7:0]  BASE  = 8'hC0
) (
    input  logic [SEL_W-1:0] ad_hi,
    input  logic [3:0]       cmd,
    output logic             hit_rd,
    output logic             hit_wr,
    output logic             is_cfg
);
    import pbus_pkg::*;

    logic in_window;

    always_comb begin
        in_window = (ad_hi == BASE[SEL_W-1:0]);
        hit_rd    = in_window && (cmd == CMD_MEM_RD);
        hit_wr    = in_window && (cmd == CMD_MEM_WR);
        is_cfg    = (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
    end
endmodule

// File: rtl/pbus_wait_ctr.sv
module pbus_wait_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (dec && (cnt_q != '0))
            cnt_d = cnt_q - 1'b1;
        zero = (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/pbus_pin_map.sv
module pbus_pin_map
    import pbus_pkg::*;
#(
    parameter int AD_W = 32
) (
    input  state_t              st,
    input  logic                is_wr,
    input  logic [PDATA_W-1:0]  rdata,
    output logic [AD_W-1:0]     ad_out,
    output logic                ad_oe,
    output logic [3:0]          cbe_n_out,
    output logic                cbe_oe,
    output logic                par_out,
    output logic                par_oe,
    output logic                perr_n_out,
    output logic                perr_oe,
    output logic                parchk_en,
    output logic                trdy_n,
    output logic                devsel_n,
    output logic                stop_n,
    output logic                ce_n
);
    logic active, pins_on, strobe_on;

    always_comb begin
        active    = (st == S_DECODE) || (st == S_LEAD) ||
                    (st == S_STROBE) || (st == S_READY);
        pins_on   = (st == S_LEAD) || (st == S_STROBE) || (st == S_READY);
        strobe_on = (st == S_STROBE);

        cbe_n_out[0] = !(strobe_on && !is_wr);
        cbe_n_out[1] = !(strobe_on && is_wr);
        cbe_n_out[2] = !strobe_on;
        cbe_n_out[3] = 1'b1;
        cbe_oe       = pins_on;
        ce_n         = !pins_on;

        devsel_n   = !active;
        trdy_n     = !(st == S_READY);
        stop_n     = !(st == S_ABORT);

        ad_oe      = (st == S_READY) && !is_wr;
        ad_out     = {{(AD_W-PDATA_W){1'b0}}, rdata};

        par_oe     = active;
        perr_oe    = active;
        par_out    = 1'b0;
        perr_n_out = 1'b1;
        parchk_en  = !active;
    end
endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
    import pbus_pkg::*;
#(
    parameter int         AD_W   = 32,
    parameter int         WAIT_W = 4,
    parameter logic [7:0] BASE   = 8'hC0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_n,
    input  logic                irdy_n,
    input  logic [AD_W-1:0]     ad_in,
    input  logic [3:0]          cbe_n_in,
    input  logic [WAIT_W-1:0]   wait_cfg,
    input  logic [7:0]          pdata_in,
    output logic [AD_W-1:0]     ad_out,
    output logic                ad_oe,
    output logic [3:0]          cbe_n_out,
    output logic                cbe_oe,
    output logic                par_out,
    output logic                par_oe,
    output logic                perr_n_out,
    output logic                perr_oe,
    output logic                parchk_en,
    output logic                trdy_n,
    output logic                devsel_n,
    output logic                stop_n,
    output logic                ce_n,
    output logic [23:0]         paddr,
    output logic [7:0]          pdata_out
);
    localparam int SEL_W = AD_W - PADDR_W;

    ctl_t ctl_d, ctl_q;
    logic hit_rd, hit_wr, is_cfg;
    logic cnt_load, cnt_dec, cnt_zero;

    pbus_decode #(.SEL_W(SEL_W), .BASE(BASE)) u_dec (
        .ad_hi  (ad_in[AD_W-1:PADDR_W]),
        .cmd    (cbe_n_in),
        .hit_rd (hit_rd),
        .hit_wr (hit_wr),
        .is_cfg (is_cfg)
    );

    pbus_wait_ctr #(.W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (wait_cfg),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    always_comb begin
        ctl_d    = ctl_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        case (ctl_q.st)
            S_IDLE: begin
                if (!frame_n) begin
                    if (hit_rd || hit_wr) begin
                        ctl_d.st    = S_DECODE;
                        ctl_d.is_wr = hit_wr;
                        ctl_d.addr  = ad_in[PADDR_W-1:0];
                    end else if (is_cfg) begin
                        ctl_d.st = S_ABORT;
                    end
                end
            end
            S_DECODE: begin
                ctl_d.wdata = ad_in[PDATA_W-1:0];
                ctl_d.st    = frame_n ? S_LEAD : S_ABORT;
            end
            S_LEAD: begin
                cnt_load = 1'b1;
                ctl_d.st = S_STROBE;
            end
            S_STROBE: begin
                if (cnt_zero) begin
                    ctl_d.st = S_READY;
                    if (!ctl_q.is_wr) ctl_d.rdata = pdata_in;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            S_READY: begin
                if (!irdy_n) ctl_d.st = S_IDLE;
            end
            S_ABORT: begin
                if (frame_n) ctl_d.st = S_IDLE;
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st    <= S_IDLE;
            ctl_q.is_wr <= 1'b0;
            ctl_q.addr  <= '0;
            ctl_q.wdata <= '0;
            ctl_q.rdata <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pbus_pin_map #(.AD_W(AD_W)) u_pins (
        .st         (ctl_q.st),
        .is_wr      (ctl_q.is_wr),
        .rdata      (ctl_q.rdata),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .cbe_n_out  (cbe_n_out),
        .cbe_oe     (cbe_oe),
        .par_out    (par_out),
        .par_oe     (par_oe),
        .perr_n_out (perr_n_out),
        .perr_oe    (perr_oe),
        .parchk_en  (parchk_en),
        .trdy_n     (trdy_n),
        .devsel_n   (devsel_n),
        .stop_n     (stop_n),
        .ce_n       (ce_n)
    );

    assign paddr     = ctl_q.addr;
    assign pdata_out = ctl_q.wdata;

    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cbe_oe |-> (cbe_n_out[1:0] != 2'b00));

    p_ce_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cbe_n_out[2]) |-> $past(!ce_n));

    p_trdy_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n) |=> trdy_n);

    p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n |-> (devsel_n && trdy_n && !cbe_oe));

    p_parity_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |-> (par_oe && perr_oe && !parchk_en && !devsel_n));

    p_rdata_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (!trdy_n && $past(cbe_oe)));
endmodule

// File: tb/sim_pbus_bridge.sv
module sim_pbus_bridge;
    localparam logic [7:0] BASE = 8'hC0;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_n, irdy_n;
    logic [31:0] ad_in;
    logic [3:0]  cbe_n_in;
    logic [3:0]  wait_cfg;
    logic [7:0]  pdata_in;
    logic [31:0] ad_out;
    logic        ad_oe, cbe_oe, par_out, par_oe, perr_n_out, perr_oe, parchk_en;
    logic [3:0]  cbe_n_out;
    logic        trdy_n, devsel_n, stop_n, ce_n;
    logic [23:0] paddr;
    logic [7:0]  pdata_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pbus_bridge #(.BASE(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .ad_in(ad_in), .cbe_n_in(cbe_n_in), .wait_cfg(wait_cfg),
        .pdata_in(pdata_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .cbe_n_out(cbe_n_out), .cbe_oe(cbe_oe), .par_out(par_out),
        .par_oe(par_oe), .perr_n_out(perr_n_out), .perr_oe(perr_oe),
        .parchk_en(parchk_en), .trdy_n(trdy_n), .devsel_n(devsel_n),
        .stop_n(stop_n), .ce_n(ce_n), .paddr(paddr), .pdata_out(pdata_out)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; ad_in = '0;
        cbe_n_in = 4'hF; wait_cfg = '0; pdata_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({trdy_n, devsel_n, stop_n, ce_n} == 4'hF, "R1 handshake idle",
            {trdy_n, devsel_n, stop_n, ce_n}, 4'hF);
        chk({cbe_oe, ad_oe, par_oe, perr_oe} == 4'h0, "R1 enables idle",
            {cbe_oe, ad_oe, par_oe, perr_oe}, 4'h0);
        chk(parchk_en == 1'b1, "R1 parity check enabled", parchk_en, 1);
    endtask

    task automatic t_xfer(input bit wr, input int w, input logic [23:0] a,
                          input logic [7:0] d, input logic [7:0] rv);
        int ce_first = -1, ce_last = -1, stb_first = -1, stb_last = -1;
        int stb_cnt = 0, trdy_cnt = 0, trdy_i = -1;
        bit kind_ok = 1, addr_ok = 1, wd_ok = 1, par_ok = 1, oe_seen = 0;
        logic [31:0] rd_word = '0;
        string tg;
        tg = wr ? "write" : "read";
        wait_cfg = w[3:0];
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1;
        cbe_n_in = wr ? 4'b0111 : 4'b0110;
        ad_in = {BASE, a};
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b0; cbe_n_in = 4'b1110;
        ad_in = {24'h5A5A5A, d};
        for (int i = 0; i < 30; i++) begin
            if (!ce_n) begin
                if (ce_first < 0) ce_first = i;
                ce_last = i;
            end
            if (cbe_oe && !cbe_n_out[2]) begin
                stb_cnt++;
                if (stb_first < 0) stb_first = i;
                stb_last = i;
                if (cbe_n_out[3:0] != (wr ? 4'b1001 : 4'b1010)) kind_ok = 0;
                if (paddr != a) addr_ok = 0;
                if (wr && pdata_out != d) wd_ok = 0;
                pdata_in = (stb_cnt == w + 1) ? rv : ~rv;
            end
            if (!trdy_n) begin
                trdy_cnt++;
                trdy_i = i;
                rd_word = ad_out;
                oe_seen = ad_oe;
            end
            if (!devsel_n && !(par_oe && perr_oe && !par_out && perr_n_out && !parchk_en))
                par_ok = 0;
            @(negedge clk);
            if (i == 0) ad_in = {24'h0, ~d};
            if (trdy_i >= 0 && i >= trdy_i) irdy_n = 1'b1;
        end
        chk(ce_first >= 0, {"R2 claimed ", tg}, ce_first, 0);
        chk(kind_ok, {"R3 strobe pattern ", tg}, kind_ok, 1);
        chk(stb_cnt == w + 1, {"R4 strobe width ", tg}, stb_cnt, w + 1);
        chk(stb_first == ce_first + 1, {"R5 ce lead ", tg}, stb_first, ce_first + 1);
        chk(ce_last == stb_last + 1, {"R5 ce trail ", tg}, ce_last, stb_last + 1);
        chk(trdy_cnt == 1, {"R6 trdy count ", tg}, trdy_cnt, 1);
        chk(trdy_i == stb_last + 1, {"R6 trdy position ", tg}, trdy_i, stb_last + 1);
        chk(addr_ok, {"R8 paddr ", tg}, paddr, a);
        chk(par_ok, {"R9 parity pins ", tg}, par_ok, 1);
        chk(parchk_en == 1'b1, {"R9 parity check restored ", tg}, parchk_en, 1);
        if (wr) begin
            chk(wd_ok, "R8 write data held", pdata_out, d);
            chk(!oe_seen, "R7 no drive on write", oe_seen, 0);
        end else begin
            chk(rd_word == {24'h0, rv}, "R7 read word", rd_word, {24'h0, rv});
            chk(oe_seen, "R7 ad_oe at trdy", oe_seen, 1);
        end
    endtask

    task automatic t_miss();
        bit quiet = 1;
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; cbe_n_in = 4'b0110;
        ad_in = {BASE + 8'h01, 24'h000010};
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b0; cbe_n_in = 4'b1110;
        for (int i = 0; i < 8; i++) begin
            if (!devsel_n || cbe_oe || !ce_n || !trdy_n || !stop_n) quiet = 0;
            @(negedge clk);
        end
        irdy_n = 1'b1;
        chk(quiet, "R2 outside window ignored", quiet, 1);
    endtask

    task automatic t_abort(input bit burst, input logic [3:0] cmd);
        bit stop_seen = 0, sel_seen = 0, stb_seen = 0, trdy_seen = 0;
        string tg;
        tg = burst ? "R11 burst" : "R10 config";
        wait_cfg = 4'd2;
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; cbe_n_in = cmd;
        ad_in = {BASE, 24'h000200};
        @(negedge clk);
        frame_n = burst ? 1'b0 : 1'b1; irdy_n = 1'b0; cbe_n_in = 4'b1110;
        for (int i = 0; i < 10; i++) begin
            if (!stop_n) stop_seen = 1;
            if (!stop_n && !devsel_n) sel_seen = 1;
            if (cbe_oe && cbe_n_out[2:0] != 3'b111) stb_seen = 1;
            if (!trdy_n) trdy_seen = 1;
            @(negedge clk);
            if (i == 2) frame_n = 1'b1;
            if (i == 3) irdy_n = 1'b1;
        end
        chk(stop_seen, {tg, " stop asserted"}, stop_seen, 1);
        chk(!sel_seen, {tg, " devsel high during abort"}, sel_seen, 0);
        chk(!stb_seen, {tg, " no strobe"}, stb_seen, 0);
        chk(!trdy_seen, {tg, " no trdy"}, trdy_seen, 0);
        chk(stop_n && devsel_n, {tg, " back to idle"}, {stop_n, devsel_n}, 2'b11);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_xfer(1'b0, 0,  24'h123456, 8'h00, 8'h3C);
        t_xfer(1'b0, 5,  24'hE00001, 8'h00, 8'hA7);
        t_xfer(1'b1, 0,  24'h00FF00, 8'h96, 8'h00);
        t_xfer(1'b1, 15, 24'hFFFFFF, 8'h5B, 8'h00);
        t_xfer(1'b0, 15, 24'h000000, 8'h00, 8'hFF);
        t_miss();
        t_abort(1'b0, 4'b1010);
        t_abort(1'b0, 4'b1011);
        t_abort(1'b1, 4'b0110);
        t_xfer(1'b1, 3,  24'h800000, 8'h01, 8'h00);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule